// File: doc/BRIEF.md
# Addressed SPI Command Decoder

This block is the serial control front end of a device that shares one SPI bus with other devices of the same kind. Each device holds a 4-bit chip address. A frame is 16 bits long, and its top nibble selects which devices act on it. Every device also obeys address 0x0 and the broadcast address 0xF. The lower twelve bits form a fixed command code or a command with its operand. The decoder keeps a driver-enable flag and a configuration-state flag. It also holds a 32-entry by 16-bit register file, which is written a byte at a time through a latched register pointer.

The serial pins run in SPI mode 1, MSB first. The device samples SDI on the falling SCLK edge and launches SDO on the rising edge. All pins are oversampled by the system clock after a synchronizer. Each accepted frame loads the word that the next frame shifts out: the addressed register contents after a read, or an echo of the received frame after any other accepted command. Only a valid command to the device's own address turns on the SDO driver, so the serial output can share a bus line. A foreign frame or a broadcast frame releases SDO again.

Top module: `addr_spi_cmd_decoder`

## Requirements
- R1: A frame counts only if exactly 16 falling SCLK edges occur while chip select is low. A frame with any other count changes no state or response, and it sets the error flag.
- R2: A frame is acted on when bits 15:12 equal the programmed chip address, 0x0 or 0xF. Any other address is ignored.
- R3: sdo_oe goes high after a known command to the device's own address. It goes low after any frame to a foreign address or to 0xF. A frame to 0x0 leaves it unchanged, and so does an ignored frame to the own address.
- R4: Bits 11:0 = 0x009 set drv_en and clear cfg_mode. Bits 11:0 = 0x00A clear drv_en. Bits 11:0 = 0x222 set cfg_mode and clear drv_en. Bits 11:0 = 0x542 changes nothing but the response.
- R5: Bits 11:5 = 1100000 latch bits 4:0 as the register pointer. Bits 11:8 = 1010 write bits 7:0 into bits 15:8 of the pointed register. Bits 11:8 = 1011 write bits 7:0 into bits 7:0 of that register.
- R6: Bits 11:5 = 0001000 make the next frame shift out the 16-bit register addressed by bits 4:0.
- R7: Every other accepted known command makes the next frame shift out the received frame itself. An ignored frame leaves the pending response unchanged.
- R8: A frame with bits 15:4 = 0xFDA loads bits 3:0 as the new chip address, but only while addr_prog_en is high.
- R9: Bits 11:0 = 0x708 return every register to its default of 0x0000, clear the pointer, clear drv_en and clear cfg_mode. The chip address is kept.
- R10: An addressed frame whose command matches no encoding changes no state and sets err_flag. err_flag stays set until err_clr is pulsed.
- R11: SDO carries the response MSB first, with one bit launched per rising SCLK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low chip select, frames one transfer |
| sdi | input | 1 | Serial data in |
| addr_prog_en | input | 1 | Qualifier that permits chip-address writes |
| err_clr | input | 1 | Clears the sticky error flag |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the shared SDO line |
| drv_en | output | 1 | Driver enable state |
| cfg_mode | output | 1 | Configuration state flag |
| err_flag | output | 1 | Sticky error: bad frame length or unknown command |

## Verification
The test sequence sends frames with four kinds of address: the own address, address 0x0, the broadcast address and a foreign address. These separate the frames that are executed from those that are ignored, and they show how each kind moves sdo_oe. Each frame's shifted-out word is compared with the expected read data or echo. This separates a read from an echo, and it also shows whether an ignored frame disturbed the pending response. The address-write frame is sent once with the qualifier low and once with it high, and the old and new addresses are then tried. Frames of 15 and 17 clocks, and a command code next to the read encoding, check that bad frames are discarded and raise the error flag.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   localparam int FRAME_W = 16;

   typedef enum logic [3:0] {
      OP_NONE, OP_DRV_ON, OP_DRV_OFF, OP_CFG, OP_NOP, OP_SRST,
      OP_READ, OP_WR_HI, OP_WR_LO, OP_PTR, OP_SET_ADDR
   } op_e;

   function automatic op_e decode_op(input logic [FRAME_W-1:0] f);
      decode_op = OP_NONE;
      if (f[15:4] == 12'hFDA)          decode_op = OP_SET_ADDR;
      else if (f[11:0] == 12'h009)     decode_op = OP_DRV_ON;
      else if (f[11:0] == 12'h00A)     decode_op = OP_DRV_OFF;
      else if (f[11:0] == 12'h222)     decode_op = OP_CFG;
      else if (f[11:0] == 12'h542)     decode_op = OP_NOP;
      else if (f[11:0] == 12'h708)     decode_op = OP_SRST;
      else if (f[11:5] == 7'b0001000)  decode_op = OP_READ;
      else if (f[11:5] == 7'b1100000)  decode_op = OP_PTR;
      else if (f[11:8] == 4'b1010)     decode_op = OP_WR_HI;
      else if (f[11:8] == 4'b1011)     decode_op = OP_WR_LO;
   endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
   import spi_cmd_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               cs_n_s,
   input  logic               sdi_s,
   input  logic [FRAME_W-1:0] tx_word,
   output logic               frame_ok,
   output logic               frame_bad,
   output logic [FRAME_W-1:0] rx_word,
   output logic               sdo_bit
);
   localparam int CW  = $clog2(FRAME_W + 2);
   localparam logic [CW-1:0] LIM = CW'(FRAME_W + 1);
   localparam logic [CW-1:0] EXP = CW'(FRAME_W);

   logic               sclk_q, cs_q;
   logic [CW-1:0]      cnt;
   logic [FRAME_W-1:0] tx_sh;
   logic               rise, fall, cs_fall, cs_rise;

   assign rise    =  sclk_s & ~sclk_q;
   assign fall    = ~sclk_s &  sclk_q;
   assign cs_fall = ~cs_n_s &  cs_q;
   assign cs_rise =  cs_n_s & ~cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q    <= 1'b0;
         cs_q      <= 1'b1;
         cnt       <= '0;
         tx_sh     <= '0;
         rx_word   <= '0;
         sdo_bit   <= 1'b0;
         frame_ok  <= 1'b0;
         frame_bad <= 1'b0;
      end else begin
         sclk_q    <= sclk_s;
         cs_q      <= cs_n_s;
         frame_ok  <= 1'b0;
         frame_bad <= 1'b0;
         if (cs_fall) begin
            cnt   <= '0;
            tx_sh <= tx_word;
         end else if (cs_rise) begin
            frame_ok  <= (cnt == EXP);
            frame_bad <= (cnt != EXP);
         end else if (!cs_n_s) begin
            if (rise) begin
               sdo_bit <= tx_sh[FRAME_W-1];
               tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
            end
            if (fall) begin
               rx_word <= {rx_word[FRAME_W-2:0], sdi_s};
               if (cnt != LIM) cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R1: a completed frame is reported for one cycle only
   a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok |=> !frame_ok);
   // R1: a frame is never both accepted and rejected
   a_r1_ok_or_bad: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_ok && frame_bad));
endmodule

// File: rtl/spi_cmd_exec.sv
module spi_cmd_exec
   import spi_cmd_pkg::*;
#(
   parameter int                 DEPTH   = 32,
   parameter logic [3:0]         OWN_RST = 4'h3,
   parameter logic [FRAME_W-1:0] REG_RST = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_ok,
   input  logic               frame_bad,
   input  logic [FRAME_W-1:0] rx_word,
   input  logic               prog_en_s,
   input  logic               err_clr,
   output logic               drv_en,
   output logic               cfg_mode,
   output logic               err_flag,
   output logic               sdo_oe,
   output logic [FRAME_W-1:0] tx_word
);
   localparam int AW = $clog2(DEPTH);

   logic [3:0]                    own_addr;
   logic [AW-1:0]                 ptr;
   logic [DEPTH-1:0][FRAME_W-1:0] regs;
   logic [3:0]                    fa;
   logic                          hit_own, hit, known, run;
   op_e                           op;

   assign fa      = rx_word[15:12];
   assign hit_own = (fa == own_addr);
   assign hit     = hit_own || (fa == 4'h0) || (fa == 4'hF);
   assign op      = decode_op(rx_word);
   assign known   = (op != OP_NONE);
   assign run     = frame_ok && hit && known;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_addr <= OWN_RST;
         ptr      <= '0;
         regs     <= {DEPTH{REG_RST}};
         drv_en   <= 1'b0;
         cfg_mode <= 1'b0;
         err_flag <= 1'b0;
         sdo_oe   <= 1'b0;
         tx_word  <= '0;
      end else begin
         if (err_clr) err_flag <= 1'b0;
         if (frame_bad || (frame_ok && hit && !known)) err_flag <= 1'b1;
         if (frame_ok) begin
            if (fa == 4'hF || !hit)  sdo_oe <= 1'b0;
            else if (hit_own && known) sdo_oe <= 1'b1;
         end
         if (run) begin
            tx_word <= rx_word;
            unique case (op)
               OP_DRV_ON:   begin drv_en <= 1'b1; cfg_mode <= 1'b0; end
               OP_DRV_OFF:  drv_en <= 1'b0;
               OP_CFG:      begin cfg_mode <= 1'b1; drv_en <= 1'b0; end
               OP_SRST: begin
                  regs     <= {DEPTH{REG_RST}};
                  ptr      <= '0;
                  drv_en   <= 1'b0;
                  cfg_mode <= 1'b0;
               end
               OP_READ:     tx_word <= regs[rx_word[AW-1:0]];
               OP_PTR:      ptr <= rx_word[AW-1:0];
               OP_WR_HI:    regs[ptr][15:8] <= rx_word[7:0];
               OP_WR_LO:    regs[ptr][7:0]  <= rx_word[7:0];
               OP_SET_ADDR: if (prog_en_s) own_addr <= rx_word[3:0];
               default:     ;
            endcase
         end
      end
   end

   // R3: foreign or broadcast frames release the shared line
   a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_ok && rx_word[15:12] != own_addr && rx_word[15:12] != 4'h0) |=> !sdo_oe);
   // R4: driver state moves only on a completed frame
   a_r4_drv_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_ok |=> $stable(drv_en));
   // R4: driver enable and configuration state exclude each other
   a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(drv_en && cfg_mode));
   // R8: chip address is frozen while the qualifier is low
   a_r8_addr_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_en_s |=> $stable(own_addr));
   // R1: a bad-length frame raises the error flag
   a_r1_bad_err: assert property (@(posedge clk) disable iff (!rst_n)
      frame_bad |=> err_flag);
endmodule

// File: rtl/addr_spi_cmd_decoder.sv
module addr_spi_cmd_decoder
   import spi_cmd_pkg::*;
#(
   parameter int                 REG_DEPTH    = 32,
   parameter int                 SYNC_STAGES  = 2,
   parameter logic [3:0]         OWN_ADDR_RST = 4'h3,
   parameter logic [FRAME_W-1:0] REG_RST      = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic sdi,
   input  logic addr_prog_en,
   input  logic err_clr,
   output logic sdo,
   output logic sdo_oe,
   output logic drv_en,
   output logic cfg_mode,
   output logic err_flag
);
   generate
      if (REG_DEPTH < 2 || REG_DEPTH > 32 || (REG_DEPTH & (REG_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("REG_DEPTH must be a power of two from 2 to 32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [3:0]         pins_s;
   logic               frame_ok, frame_bad;
   logic [FRAME_W-1:0] rx_word, tx_word;

   spi_in_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({sclk, cs_n, sdi, addr_prog_en}),
      .q(pins_s)
   );

   spi_frame_shifter u_shift (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(pins_s[3]), .cs_n_s(pins_s[2]), .sdi_s(pins_s[1]),
      .tx_word(tx_word),
      .frame_ok(frame_ok), .frame_bad(frame_bad),
      .rx_word(rx_word), .sdo_bit(sdo)
   );

   spi_cmd_exec #(.DEPTH(REG_DEPTH), .OWN_RST(OWN_ADDR_RST), .REG_RST(REG_RST)) u_exec (
      .clk(clk), .rst_n(rst_n),
      .frame_ok(frame_ok), .frame_bad(frame_bad), .rx_word(rx_word),
      .prog_en_s(pins_s[0]), .err_clr(err_clr),
      .drv_en(drv_en), .cfg_mode(cfg_mode), .err_flag(err_flag),
      .sdo_oe(sdo_oe), .tx_word(tx_word)
   );
endmodule

// File: tb/addr_spi_cmd_decoder_test.sv
module addr_spi_cmd_decoder_test;
   logic clk = 1'b0, rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, prog = 1'b0, eclr = 1'b0;
   logic sdo, sdo_oe, drv_en, cfg_mode, err_flag;
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;
   localparam int H = 6;

   always #2 clk = ~clk;

   addr_spi_cmd_decoder uut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
      .addr_prog_en(prog), .err_clr(eclr), .sdo(sdo), .sdo_oe(sdo_oe),
      .drv_en(drv_en), .cfg_mode(cfg_mode), .err_flag(err_flag)
   );

   // {frame, addr_prog_en, response shifted out during this frame, drv cfg oe err after}
   localparam logic [36:0] VEC [19] = '{
      {16'h3009, 1'b0, 16'h0000, 4'b1010},  // R4 driver on, R3 own address drives SDO
      {16'h3222, 1'b0, 16'h3009, 4'b0110},  // R4 configuration, R7 echo
      {16'h3C05, 1'b0, 16'h3222, 4'b0110},  // R5 pointer to 5
      {16'h3AAB, 1'b0, 16'h3C05, 4'b0110},  // R5 high byte
      {16'h0BCD, 1'b0, 16'h3AAB, 4'b0110},  // R2 address 0, R5 low byte
      {16'h3105, 1'b0, 16'h0BCD, 4'b0110},  // R6 read register 5
      {16'h3542, 1'b0, 16'hABCD, 4'b0110},  // R6 read data, R11 order, R4 no-op
      {16'h5009, 1'b0, 16'h3542, 4'b0100},  // R2 foreign ignored, R3 release
      {16'hF009, 1'b0, 16'h3542, 4'b1000},  // R2 broadcast acts, R7 ignored kept response
      {16'h3123, 1'b0, 16'hF009, 4'b1001},  // R10 unknown command
      {16'h300A, 1'b0, 16'hF009, 4'b0011},  // R10 no state change, R4 driver off
      {16'hFDA7, 1'b0, 16'h300A, 4'b0001},  // R8 qualifier low
      {16'hFDA7, 1'b1, 16'hFDA7, 4'b0001},  // R8 qualifier high
      {16'h3009, 1'b0, 16'hFDA7, 4'b0001},  // R8 old address now foreign
      {16'h7009, 1'b0, 16'hFDA7, 4'b1011},  // R8 new address accepted
      {16'h7105, 1'b0, 16'h7009, 4'b1011},  // R6 read again
      {16'h7708, 1'b0, 16'hABCD, 4'b0011},  // R9 software reset
      {16'h7105, 1'b0, 16'h7708, 4'b0011},  // R9 read after reset
      {16'h7542, 1'b0, 16'h0000, 4'b0011}   // R9 register back to default
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic frame(input logic [15:0] w, input int nclk, output logic [15:0] got);
      got = '0;
      @(negedge clk) cs_n = 1'b0;
      repeat (H) @(negedge clk);
      for (int i = 0; i < nclk; i++) begin
         sclk = 1'b1;
         sdi  = (i < 16) ? w[15-i] : 1'b0;
         repeat (H) @(negedge clk);
         got  = {got[14:0], sdo};
         sclk = 1'b0;
         repeat (H) @(negedge clk);
      end
      cs_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      logic [15:0] got;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("reset drv_en", {15'd0, drv_en}, 16'd0);
      chk("reset cfg_mode", {15'd0, cfg_mode}, 16'd0);
      chk("reset sdo_oe R3", {15'd0, sdo_oe}, 16'd0);
      chk("reset err_flag", {15'd0, err_flag}, 16'd0);

      for (int k = 0; k < 19; k++) begin
         prog = VEC[k][20];
         frame(VEC[k][36:21], 16, got);
         chk($sformatf("R6/R7/R11 response row %0d", k), got, VEC[k][19:4]);
         chk($sformatf("R4 drv_en row %0d", k), {15'd0, drv_en}, {15'd0, VEC[k][3]});
         chk($sformatf("R4 cfg_mode row %0d", k), {15'd0, cfg_mode}, {15'd0, VEC[k][2]});
         chk($sformatf("R3 sdo_oe row %0d", k), {15'd0, sdo_oe}, {15'd0, VEC[k][1]});
         chk($sformatf("R10 err_flag row %0d", k), {15'd0, err_flag}, {15'd0, VEC[k][0]});
         prog = 1'b0;
      end

      // R10: clearing the sticky flag
      @(negedge clk) eclr = 1'b1;
      @(negedge clk) eclr = 1'b0;
      @(negedge clk);
      chk("R10 err cleared", {15'd0, err_flag}, 16'd0);

      // R1: 15 clocks discarded
      frame(16'h7009, 15, got);
      chk("R1 short frame drv_en", {15'd0, drv_en}, 16'd0);
      chk("R1 short frame err", {15'd0, err_flag}, 16'd1);
      @(negedge clk) eclr = 1'b1;
      @(negedge clk) eclr = 1'b0;

      // R1: 17 clocks discarded
      frame(16'h7009, 17, got);
      chk("R1 long frame drv_en", {15'd0, drv_en}, 16'd0);
      chk("R1 long frame err", {15'd0, err_flag}, 16'd1);

      // R1: a proper frame still sees the response left before the bad ones
      frame(16'h7009, 16, got);
      chk("R1 response kept", got, 16'h7542);
      chk("R1 good frame drv_en", {15'd0, drv_en}, 16'd1);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule